// File: doc/BRIEF.md
# Gated 13-Bit Timer/Counter Pair

This block holds two identical 13-bit counting channels. Each channel keeps its count in a 5-bit low byte and an 8-bit high byte. It advances on one of three sources: every system clock, each pulse of a prescaled tick input, or each falling edge of the channel's own external count pin. An external gate pin can also hold the count back. The gate pin is XORed with a per-channel polarity bit, so software chooses whether high or low means "open". A channel can therefore time pulse widths on that pin.

Software programs the block through a small register bus and preloads the count bytes before it starts a channel. When a count wraps from all ones to zero, the channel raises a sticky overflow flag. Software clears that flag, or an interrupt acknowledge pulse clears it. The count pins and gate pins pass through a two-flop synchroniser first.

Top module: `gtc_timer_pair`

## Requirements
- R1: After a synchronous reset, every register reads 0: all counts, mode bits, run bits, polarity bits and overflow flags. Both channels are stopped and `ovf_flag` is 0.
- R2: A channel's count holds its value in either of two cases: its run bit is 0, or its gate enable bit is 1 and its gate is closed.
- R3: When the external-count select bit of a channel is 0, the clock select bit picks the count source. A value of 1 counts once on every clock. A value of 0 counts once on each clock in which `prescale_tick` is high.
- R4: When the external-count select bit is 1, the count advances by exactly one for each falling edge of the channel's `cnt_pin`, and rising edges do not count. The pin passes through two synchroniser flops and an edge register, so the count changes on the third rising clock edge after the pin falls.
- R5: The gate is open when the synchronised `gate_pin` XOR the channel's polarity bit equals 1. So polarity 0 counts while the pin is high and polarity 1 counts while it is low. The gate has an effect only when the gate enable bit is 1.
- R6: Setting the run bit does not change the count. Counting resumes from the value held in the count bytes.
- R7: The count is 13 bits: the low byte supplies bits 4:0 and the high byte supplies bits 12:5. A read of a low byte returns 0 in bits 7:5, whatever was written there.
- R8: When an enabled increment takes the count from 0x1FFF to 0x0000, the channel's overflow flag is set on that clock edge. This takes priority over any clear in the same cycle.
- R9: The overflow flag stays at 1 until one of two things happens: a write to the control register with the flag's bit at 0, or a pulse on the channel's `irq_ack` bit.
- R10: A bus write to either count byte of a channel in the same cycle as an increment loads the written byte, and that channel does not increment in that cycle.
- R11: The two channels are independent: each has its own mode, run, polarity and flag bits, its own pins and its own count.
- R12: Register map on a 3-bit address.
  - Address 0 is the mode register. For channel c, bit 4c selects external count, bit 4c+1 enables the gate and bit 4c+2 selects the system clock.
  - Address 1 is the control register. Bit c is run and bit 4+c is the overflow flag.
  - Address 2 is the polarity register, with bit c for channel c.
  - Addresses 4 and 5 are the low and high bytes of channel 0, and addresses 6 and 7 are those of channel 1. Address 3 reads 0.
  - `bus_rdata` is registered: it shows the register at `bus_addr` as it stood before the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| prescale_tick | input | 1 | Prescaled count pulse, one clock wide |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | External gate pins, one per channel |
| irq_ack | input | 2 | Overflow acknowledge pulses, one per channel |
| ovf_flag | output | 2 | Sticky overflow flags |

## Verification
The embedded properties check four things on every cycle:
- a stopped or gated-off channel keeps its count;
- a count-byte write lands in place of the increment;
- a wrap from all ones sets the flag and an acknowledge clears it;
- each synchronised falling edge gives a single-cycle pulse, and the low-byte pad bits read as zero.

Source selection, the gate polarity, independence of the channels and the exact latency from pin to count are only visible through scenarios. The bench's behavioural model follows those scenarios and compares the read data and flags every clock.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_POL  = 3'd2;
  localparam int CNT_BASE = 4;
  localparam int FLAG_BIT_BASE = 4;
  localparam int MODE_STRIDE = 4;

  typedef struct packed {
    logic sys_sel;
    logic gate_en;
    logic ext_sel;
  } chan_mode_t;

  function automatic logic [ADDR_W-1:0] cnt_lo_addr(input int c);
    return ADDR_W'(CNT_BASE + 2 * c);
  endfunction

  function automatic logic [ADDR_W-1:0] cnt_hi_addr(input int c);
    return ADDR_W'(CNT_BASE + 2 * c + 1);
  endfunction
endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign fall = prev_q & ~lvl;

  // R4: each detected falling edge is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (fall != '0) |=> ((fall & $past(fall)) == '0));
endmodule

// File: rtl/gtc_channel.sv
module gtc_channel #(
  parameter int LO_W = 5,
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            gate_en,
  input  logic            ext_sel,
  input  logic            sys_sel,
  input  logic            gate_pol,
  input  logic            prescale_tick,
  input  logic            pin_fall,
  input  logic            gate_lvl,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic [HI_W-1:0] wdata,
  input  logic            flag_we,
  input  logic            flag_wval,
  input  logic            ack,
  output logic [LO_W-1:0] cnt_lo,
  output logic [HI_W-1:0] cnt_hi,
  output logic            flag
);
  localparam int CNT_W = LO_W + HI_W;

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             gate_open, cnt_en, tick, inc, wrap;

  assign gate_open = ~gate_en | (gate_lvl ^ gate_pol);
  assign cnt_en    = run & gate_open;
  assign tick      = ext_sel ? pin_fall : (sys_sel ? 1'b1 : prescale_tick);
  assign inc       = cnt_en & tick & ~lo_we & ~hi_we;
  assign wrap      = inc & (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (lo_we || hi_we) begin
        if (lo_we) cnt_q[LO_W-1:0]     <= wdata[LO_W-1:0];
        if (hi_we) cnt_q[CNT_W-1:LO_W] <= wdata;
      end else if (inc) begin
        cnt_q <= cnt_q + 1'b1;
      end
      flag_q <= wrap | (ack ? 1'b0 : (flag_we ? flag_wval : flag_q));
    end
  end

  assign cnt_lo = cnt_q[LO_W-1:0];
  assign cnt_hi = cnt_q[CNT_W-1:LO_W];
  assign flag   = flag_q;

  // R2: stopped or gated-off channel holds its count
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    ((!run || (gate_en && !(gate_lvl ^ gate_pol))) && !lo_we && !hi_we) |=> $stable(cnt_q));

  // R10: a low-byte write lands instead of an increment
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> (cnt_lo == $past(wdata[LO_W-1:0])));

  // R8: wrap from all ones sets the flag and leaves zero
  a_r8_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (run && gate_open && tick && !lo_we && !hi_we && (&cnt_q)) |=> (flag && cnt_q == '0));

  // R9: acknowledge clears the flag when no wrap happens
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !wrap) |=> !flag);
endmodule

// File: rtl/gtc_timer_pair.sv
module gtc_timer_pair
  import gtc_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int LO_W        = 5,
  parameter int HI_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HI_W-1:0]   bus_wdata,
  output logic [HI_W-1:0]   bus_rdata,
  input  logic              prescale_tick,
  input  logic [NCH-1:0]    cnt_pin,
  input  logic [NCH-1:0]    gate_pin,
  input  logic [NCH-1:0]    irq_ack,
  output logic [NCH-1:0]    ovf_flag
);
  chan_mode_t       mode_q [NCH];
  logic [NCH-1:0]   run_q, pol_q;
  logic [NCH-1:0]   cnt_lvl, cnt_fall, gate_lvl, gate_fall;
  logic [LO_W-1:0]  lo_v [NCH];
  logic [HI_W-1:0]  hi_v [NCH];
  logic [NCH-1:0]   flag_v;
  logic [HI_W-1:0]  rd_next, rdata_q;

  gtc_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst(rst), .din(cnt_pin), .lvl(cnt_lvl), .fall(cnt_fall));

  gtc_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst(rst), .din(gate_pin), .lvl(gate_lvl), .fall(gate_fall));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) mode_q[c] <= '0;
      run_q <= '0;
      pol_q <= '0;
    end else if (bus_we) begin
      for (int c = 0; c < NCH; c++) begin
        if (bus_addr == ADDR_MODE) begin
          mode_q[c].ext_sel <= bus_wdata[MODE_STRIDE*c];
          mode_q[c].gate_en <= bus_wdata[MODE_STRIDE*c+1];
          mode_q[c].sys_sel <= bus_wdata[MODE_STRIDE*c+2];
        end
        if (bus_addr == ADDR_CTRL) run_q[c] <= bus_wdata[c];
        if (bus_addr == ADDR_POL)  pol_q[c] <= bus_wdata[c];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gtc_channel #(.LO_W(LO_W), .HI_W(HI_W)) u_ch (
      .clk(clk), .rst(rst),
      .run(run_q[c]), .gate_en(mode_q[c].gate_en),
      .ext_sel(mode_q[c].ext_sel), .sys_sel(mode_q[c].sys_sel),
      .gate_pol(pol_q[c]), .prescale_tick(prescale_tick),
      .pin_fall(cnt_fall[c]), .gate_lvl(gate_lvl[c]),
      .lo_we(bus_we && bus_addr == cnt_lo_addr(c)),
      .hi_we(bus_we && bus_addr == cnt_hi_addr(c)),
      .wdata(bus_wdata),
      .flag_we(bus_we && bus_addr == ADDR_CTRL),
      .flag_wval(bus_wdata[FLAG_BIT_BASE+c]),
      .ack(irq_ack[c]),
      .cnt_lo(lo_v[c]), .cnt_hi(hi_v[c]), .flag(flag_v[c]));
  end

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_MODE) begin
        rd_next[MODE_STRIDE*c]   = mode_q[c].ext_sel;
        rd_next[MODE_STRIDE*c+1] = mode_q[c].gate_en;
        rd_next[MODE_STRIDE*c+2] = mode_q[c].sys_sel;
      end
      if (bus_addr == ADDR_CTRL) begin
        rd_next[c]                = run_q[c];
        rd_next[FLAG_BIT_BASE+c]  = flag_v[c];
      end
      if (bus_addr == ADDR_POL) rd_next[c] = pol_q[c];
      if (bus_addr == cnt_lo_addr(c)) rd_next = HI_W'(lo_v[c]);
      if (bus_addr == cnt_hi_addr(c)) rd_next = hi_v[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
  assign ovf_flag  = flag_v;

  // R7: low-byte reads carry zero in the unused upper bits
  a_r7_lo_pad: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == cnt_lo_addr(0) || bus_addr == cnt_lo_addr(NCH-1))
      |=> (bus_rdata[HI_W-1:LO_W] == '0));

  // R1: one cycle after reset the read data and flags are clear
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && ovf_flag == '0));
endmodule

// File: tb/gtc_timer_pair_tb.sv
module gtc_timer_pair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CMAX = 8192;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       prescale_tick = 1'b0;
  logic [1:0] cnt_pin = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] irq_ack = '0;
  logic [1:0] ovf_flag;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  gtc_timer_pair u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prescale_tick(prescale_tick),
    .cnt_pin(cnt_pin), .gate_pin(gate_pin), .irq_ack(irq_ack), .ovf_flag(ovf_flag));

  // behavioural reference state
  int m_cnt[2];
  bit m_flag[2], m_run[2], m_pol[2], m_ext[2], m_gen[2], m_sys[2];
  bit m_pin_hist[2][$];
  bit m_gate_hist[2][$];
  int m_rd;

  function automatic void model_reset();
    for (int c = 0; c < 2; c++) begin
      m_cnt[c] = 0; m_flag[c] = 0; m_run[c] = 0; m_pol[c] = 0;
      m_ext[c] = 0; m_gen[c] = 0; m_sys[c] = 0;
      m_pin_hist[c]  = '{0, 0, 0};
      m_gate_hist[c] = '{0, 0};
    end
    m_rd = 0;
  endfunction

  function automatic int model_read(input int a);
    int v = 0;
    case (a)
      0: for (int c = 0; c < 2; c++) v |= (m_ext[c] << (4*c)) | (m_gen[c] << (4*c+1)) | (m_sys[c] << (4*c+2));
      1: for (int c = 0; c < 2; c++) v |= (m_run[c] << c) | (m_flag[c] << (4+c));
      2: for (int c = 0; c < 2; c++) v |= (m_pol[c] << c);
      4: v = m_cnt[0] % 32;
      5: v = m_cnt[0] / 32;
      6: v = m_cnt[1] % 32;
      7: v = m_cnt[1] / 32;
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic void model_step();
    int a = int'(bus_addr);
    int d = int'(bus_wdata);
    m_rd = model_read(a);
    for (int c = 0; c < 2; c++) begin
      // pin history: index 0 newest sample; edge seen when older synced sample 1 and newer 0
      bit fall = m_pin_hist[c][2] && !m_pin_hist[c][1];
      bit glvl = m_gate_hist[c][1];
      bit open = !m_gen[c] || (glvl != m_pol[c]);
      bit tick = m_ext[c] ? fall : (m_sys[c] ? 1'b1 : prescale_tick);
      bit lo_we = bus_we && a == 4 + 2*c;
      bit hi_we = bus_we && a == 5 + 2*c;
      bit inc = m_run[c] && open && tick && !lo_we && !hi_we;
      bit wrap = inc && m_cnt[c] == CMAX - 1;
      if (lo_we) m_cnt[c] = (m_cnt[c] / 32) * 32 + (d % 32);
      if (hi_we) m_cnt[c] = (m_cnt[c] % 32) + d * 32;
      if (inc) m_cnt[c] = (m_cnt[c] + 1) % CMAX;
      if (wrap) m_flag[c] = 1;
      else if (irq_ack[c]) m_flag[c] = 0;
      else if (bus_we && a == 1) m_flag[c] = bus_wdata[4+c];
      m_pin_hist[c].push_front(cnt_pin[c]);
      void'(m_pin_hist[c].pop_back());
      m_gate_hist[c].push_front(gate_pin[c]);
      void'(m_gate_hist[c].pop_back());
    end
    if (bus_we) begin
      for (int c = 0; c < 2; c++) begin
        if (a == 0) begin
          m_ext[c] = bus_wdata[4*c]; m_gen[c] = bus_wdata[4*c+1]; m_sys[c] = bus_wdata[4*c+2];
        end
        if (a == 1) m_run[c] = bus_wdata[c];
        if (a == 2) m_pol[c] = bus_wdata[c];
      end
    end
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  initial model_reset();

  always @(negedge clk) begin
    if (rst) model_reset();
    else begin
      check(cur_req, "bus_rdata", int'(bus_rdata), m_rd);
      check(cur_req, "ovf_flag", int'(ovf_flag), int'(m_flag[0]) | (int'(m_flag[1]) << 1));
      model_step();
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input int a, input int d);
    bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd_expect(input string req, input int a, input int exp);
    bus_addr = 3'(a);
    @(posedge clk); #1;
    check(req, "direct read", int'(bus_rdata), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    cur_req = "R1";
    for (int a = 0; a < 8; a++) rd_expect("R1", a, 0);
    check("R1", "ovf_flag after reset", int'(ovf_flag), 0);

    cur_req = "R7";
    wr(4, 8'hFF); rd_expect("R7", 4, 8'h1F);
    wr(5, 8'hA5); rd_expect("R12", 5, 8'hA5);

    cur_req = "R6";
    wr(0, 8'h04); wr(1, 8'h01);
    rd_expect("R6", 4, 8'h1F);
    cur_req = "R3";
    for (int i = 0; i < 20; i++) begin bus_addr = 3'(4 + (i % 2)); idle(1); end

    cur_req = "R2";
    wr(1, 8'h00); bus_addr = 3'd4; idle(8);
    wr(4, 8'h00); wr(5, 8'h00);

    cur_req = "R3";
    wr(0, 8'h00); wr(1, 8'h01); bus_addr = 3'd4;
    for (int i = 0; i < 40; i++) begin prescale_tick = (i % 3 == 0) || (i % 7 == 0); idle(1); end
    prescale_tick = 1'b0; idle(3);

    cur_req = "R4";
    wr(0, 8'h01);
    for (int i = 0; i < 12; i++) begin
      cnt_pin[0] = 1'b1; idle(1 + i % 4);
      cnt_pin[0] = 1'b0; idle(1 + (i * 3) % 5);
    end
    idle(5);

    cur_req = "R5";
    wr(0, 8'h06); wr(2, 8'h00);
    for (int i = 0; i < 10; i++) begin gate_pin[0] = ~gate_pin[0]; idle(2 + i % 3); end
    wr(2, 8'h01);
    for (int i = 0; i < 10; i++) begin gate_pin[0] = ~gate_pin[0]; idle(3 + i % 2); end
    gate_pin[0] = 1'b0;

    cur_req = "R8";
    wr(1, 8'h00); wr(0, 8'h04);
    wr(4, 8'h1E); wr(5, 8'hFF);
    bus_addr = 3'd1; wr(1, 8'h01); idle(4);
    check("R8", "flag after wrap", int'(ovf_flag[0]), 1);
    idle(3);

    cur_req = "R9";
    irq_ack[0] = 1'b1; idle(1); irq_ack[0] = 1'b0; idle(2);
    check("R9", "flag after ack", int'(ovf_flag[0]), 0);
    wr(1, 8'h00); wr(4, 8'h1F); wr(5, 8'hFF); wr(1, 8'h01); idle(3);
    wr(1, 8'h01); idle(2);
    check("R9", "flag after write 0", int'(ovf_flag[0]), 0);

    cur_req = "R8";
    wr(1, 8'h00); wr(4, 8'h1F); wr(5, 8'hFF);
    wr(1, 8'h01); irq_ack[0] = 1'b1; idle(1); irq_ack[0] = 1'b0; idle(2);
    check("R8", "wrap beats ack", int'(ovf_flag[0]), 1);
    irq_ack[0] = 1'b1; idle(1); irq_ack[0] = 1'b0;

    cur_req = "R10";
    for (int i = 0; i < 6; i++) begin wr(4, 3 * i); idle(1); wr(5, i); end
    bus_addr = 3'd4; idle(4);

    cur_req = "R11";
    wr(1, 8'h00); wr(0, 8'h41); wr(6, 8'h10); wr(7, 8'h02); wr(1, 8'h02);
    for (int i = 0; i < 16; i++) begin bus_addr = 3'(4 + i % 4); gate_pin[1] = i[1]; idle(1); end
    wr(0, 8'h61); wr(2, 8'h02);
    for (int i = 0; i < 16; i++) begin bus_addr = 3'(6 + i % 2); gate_pin[1] = i[2]; cnt_pin[1] = i[0]; idle(1); end

    cur_req = "R12";
    for (int a = 0; a < 8; a++) begin bus_addr = 3'(a); idle(1); end
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule